// File: doc/BRIEF.md
# Protection Context Write Filter

This block holds the protection-context field of one bus master and a mask register with one bit per context value. A software write to the context field is accepted only if the mask bit for the requested value is set. A write whose own transfer runs in context 0 is privileged and skips that check. A rejected write leaves the field as it was.

Context handlers flagged valid may move the master into a context directly through a hardware entry port. A valid handler also clears its mask bit whenever the mask is written. Software therefore cannot enter a context whose entry belongs to a handler. Both registers can be read at the outputs at all times.

Top module: `pc_write_filter`

## Requirements
- R1: After reset the context output `ctx_q` is 0 and the mask output `mask_q` is all zeros.
- R2: Mask bit 0 always reads 0. Bit 0 of written mask data is dropped, and bits 1 to 15 take their written values unless R6 applies.
- R3: A context write from a transfer whose context `wr_src_ctx` is nonzero, requesting value v with `mask_q[v]`=1, sets `ctx_q` to v on the next clock edge.
- R4: A context write from a nonzero source context requesting v with `mask_q[v]`=0 is rejected, and `ctx_q` keeps its value. Because of R2, this includes v=0.
- R5: A context write from a transfer with `wr_src_ctx`=0 sets `ctx_q` to the requested value whatever the mask holds.
- R6: On a mask write, every bit i with `hnd_valid[i]`=1 stores 0, regardless of the data written.
- R7: A hardware entry (`hw_set`=1 with `hnd_valid[hw_ctx]`=1) loads `hw_ctx` into `ctx_q` on the next edge. It overrides a software context write in the same cycle.
- R8: A hardware entry whose handler is not valid (`hnd_valid[hw_ctx]`=0) has no effect. A software write in the same cycle is handled as if no entry were present.
- R9: When a context write and a mask write occur in the same cycle, the context check uses the mask value held before that cycle.
- R10: When no write and no accepted entry occur, `ctx_q` and `mask_q` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctx_we | input | 1 | Software write to the context field |
| ctx_wdata | input | 4 | Requested context value |
| wr_src_ctx | input | 4 | Protection context of the writing transfer |
| mask_we | input | 1 | Software write to the mask register |
| mask_wdata | input | 16 | Mask data written |
| hnd_valid | input | 16 | Per-context handler valid flags |
| hw_set | input | 1 | Hardware handler entry event |
| hw_ctx | input | 4 | Context entered by the hardware event |
| ctx_q | output | 4 | Current context field |
| mask_q | output | 16 | Current mask register |

## Verification
A table of context writes runs against a sparse mask. It mixes nonzero source contexts that request permitted and forbidden values, writes that request 0 from nonzero contexts, and privileged writes from context 0, so the mask lookup is tested both ways and apart from the bypass. Directed cases then write all-ones mask data under a set of valid handlers to show which bits are forced clear. Other cases pair a hardware entry with a software write, once with its handler valid and once without, to separate priority from gating. A final case changes the mask in the same cycle as a context write to confirm that the check uses the old mask.

// File: rtl/pc_write_filter.sv
module pc_write_filter #(
  parameter int CTX_W = 4,
  localparam int NCTX = 1 << CTX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctx_we,
  input  logic [CTX_W-1:0] ctx_wdata,
  input  logic [CTX_W-1:0] wr_src_ctx,
  input  logic             mask_we,
  input  logic [NCTX-1:0]  mask_wdata,
  input  logic [NCTX-1:0]  hnd_valid,
  input  logic             hw_set,
  input  logic [CTX_W-1:0] hw_ctx,
  output logic [CTX_W-1:0] ctx_q,
  output logic [NCTX-1:0]  mask_q
);

  logic hw_ok, sw_ok;
  logic [NCTX-1:0] mask_next;

  assign hw_ok     = hw_set && hnd_valid[hw_ctx];
  assign sw_ok     = ctx_we && ((wr_src_ctx == '0) || mask_q[ctx_wdata]);
  assign mask_next = mask_wdata & ~hnd_valid & ~NCTX'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctx_q <= '0;
    else if (hw_ok) ctx_q <= hw_ctx;
    else if (sw_ok) ctx_q <= ctx_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_next;
  end

  p_mask0_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[0] == 1'b0);

  p_allowed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_we && wr_src_ctx != '0 && mask_q[ctx_wdata] && !hw_ok) |=> ctx_q == $past(ctx_wdata));

  p_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_we && wr_src_ctx != '0 && !mask_q[ctx_wdata] && !hw_ok) |=> $stable(ctx_q));

  p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_we && wr_src_ctx == '0 && !hw_ok) |=> ctx_q == $past(ctx_wdata));

  p_forced_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q & $past(hnd_valid)) == '0);

  p_hw_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set && hnd_valid[hw_ctx]) |=> ctx_q == $past(hw_ctx));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctx_we && !mask_we && !hw_set) |=> ($stable(ctx_q) && $stable(mask_q)));

endmodule

// File: tb/tb_pc_write_filter.sv
module tb_pc_write_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctx_we = 1'b0, mask_we = 1'b0, hw_set = 1'b0;
  logic [3:0]  ctx_wdata = '0, wr_src_ctx = '0, hw_ctx = '0;
  logic [15:0] mask_wdata = '0, hnd_valid = '0;
  logic [3:0]  ctx_q;
  logic [15:0] mask_q;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pc_write_filter dut (
    .clk(clk), .rst_n(rst_n), .ctx_we(ctx_we), .ctx_wdata(ctx_wdata),
    .wr_src_ctx(wr_src_ctx), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .hnd_valid(hnd_valid), .hw_set(hw_set), .hw_ctx(hw_ctx),
    .ctx_q(ctx_q), .mask_q(mask_q)
  );

  // {src, data, expected ctx}; mask is 16'h00A6 (bits 1,2,5,7)
  localparam logic [11:0] VEC [10] = '{
    12'h311, 12'h331, 12'h255, 12'h105, 12'h000,
    12'h0CC, 12'h94C, 12'hF77, 12'h722, 12'h2F2
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic cw, input logic [3:0] src, input logic [3:0] cd,
                      input logic mw, input logic [15:0] md,
                      input logic hs, input logic [3:0] hc);
    @(negedge clk);
    ctx_we = cw; wr_src_ctx = src; ctx_wdata = cd;
    mask_we = mw; mask_wdata = md; hw_set = hs; hw_ctx = hc;
    @(negedge clk);
    ctx_we = 0; mask_we = 0; hw_set = 0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctx", 16'(ctx_q), 16'h0);
    chk("R1 mask", mask_q, 16'h0);

    step(0, 0, 0, 1, 16'h00A7, 0, 0);
    chk("R2 bit0 dropped", mask_q, 16'h00A6);

    for (int i = 0; i < 10; i++) begin
      step(1, VEC[i][11:8], VEC[i][7:4], 0, 0, 0, 0);
      chk($sformatf("R3/R4/R5 vec%0d", i), 16'(ctx_q), 16'(VEC[i][3:0]));
    end

    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R10 ctx hold", 16'(ctx_q), 16'h2);
    chk("R10 mask hold", mask_q, 16'h00A6);

    hnd_valid = 16'h000E;
    step(0, 0, 0, 1, 16'hFFFF, 0, 0);
    chk("R6 forced clear", mask_q, 16'hFFF0);
    step(1, 4'h6, 4'h3, 0, 0, 0, 0);
    chk("R6 sw cannot enter 3", 16'(ctx_q), 16'h2);

    hnd_valid = 16'h0008;
    step(1, 0, 4'h9, 0, 0, 1, 4'h3);
    chk("R7 hw beats sw", 16'(ctx_q), 16'h3);

    hnd_valid = 16'h0000;
    step(1, 0, 4'h9, 0, 0, 1, 4'h2);
    chk("R8 invalid hw ignored, sw applied", 16'(ctx_q), 16'h9);
    step(0, 0, 0, 0, 0, 1, 4'h1);
    chk("R8 invalid hw alone", 16'(ctx_q), 16'h9);

    step(1, 4'h5, 4'h6, 1, 16'h0000, 0, 0);
    chk("R9 old mask used", 16'(ctx_q), 16'h6);
    chk("R9 mask updated", mask_q, 16'h0000);
    step(1, 4'h5, 4'h8, 0, 0, 0, 0);
    chk("R4 after clear", 16'(ctx_q), 16'h6);

    hnd_valid = 16'h0002;
    step(0, 0, 0, 0, 0, 1, 4'h1);
    chk("R7 hw entry", 16'(ctx_q), 16'h1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule